// File: doc/BRIEF.md
# Two-Line Interrupt Flag Aggregator

This block gathers up to a parameterised number of peripheral event inputs into sticky status flags and steers them onto two interrupt outputs. A rising edge on an event input sets its flag. The flag then holds until the host writes a 1 to that bit. Writing a 0 to a flag bit does nothing.

Each flag has an enable bit and a steering bit. The steering bit chooses output 0 or output 1. Each output also has its own master gate bit. The host reads and writes four registers through a simple single-cycle port: the flags, the enables, the steering bits and the two gate bits. Reading the flags does not change them.

Top module: `irq_agg_top`

## Requirements
- R1: While rst_n is low, every flag, enable, steering and gate bit is 0, and both irq_o outputs are 0.
- R2: A flag is set on the first clock edge at which its event input is 1 after being 0 on the previous edge. An event input held high sets the flag only once.
- R3: A flag stays set until the host clears it, whatever the event input does after that.
- R4: A write to the flag register (address 0) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: If a rising event edge and a host clear of the same flag fall on the same edge, the flag ends up set.
- R6: Address 1 holds the enable bits, address 2 the steering bits (0 means line 0, 1 means line 1), and address 3 bits [1:0] the gate bits for line 0 and line 1. Each register reads back the value written to it.
- R7: A flag drives an output only while its enable bit is 1.
- R8: irq_o[k] is 1 one cycle after any flag is set, enabled and steered to line k while gate bit k is 1. Otherwise it is 0.
- R9: When gate bit k is 0, irq_o[k] is 0, whatever the flags are.
- R10: A read returns the current register contents with no side effect. Reading the flags leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NFLAG | Event inputs, one per flag |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for both read and write |
| wdata_i | input | NFLAG | Write data |
| rdata_o | output | NFLAG | Read data, combinational from addr_i |
| irq_o | output | 2 | Registered interrupt outputs, line 0 and line 1 |

## Verification
The vector table drives several event patterns against different enable, steering and gate settings:
- Single flags steered to each line show whether the steering bit picks the correct output.
- Mixed masks on the enable register show whether enable gating works per flag.
- A gate bit cleared while flags are pending shows that line gating is independent of the other line.

The directed tests cover three more cases:
- An event held high shows edge detection as opposed to level detection.
- Partial write-1-to-clear masks show that bits written as 0 are left alone.
- A clear in the same cycle as a new edge shows the event has priority.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_FLAG = 2'd0,
    REG_EN   = 2'd1,
    REG_SEL  = 2'd2,
    REG_GATE = 2'd3
  } reg_addr_e;
  localparam int unsigned NLINE = 2;
endpackage

// File: rtl/irq_agg_flags.sv
module irq_agg_flags #(
  parameter int unsigned NFLAG = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt_i,
  input  logic             clr_en_i,
  input  logic [NFLAG-1:0] clr_mask_i,
  output logic [NFLAG-1:0] flag_o
);
  logic [NFLAG-1:0] evt_q, flag_q, flag_d, rise;

  assign rise = evt_i & ~evt_q;

  always_comb begin
    flag_d = flag_q;
    if (clr_en_i) flag_d = flag_d & ~clr_mask_i;
    flag_d = flag_d | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      flag_q <= '0;
    end else begin
      evt_q  <= evt_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R5: an edge always leaves its flag set
  p_edge_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((flag_q & $past(rise)) == $past(rise)));
  // R3: no flag drops without a host clear
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en_i) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs #(
  parameter int unsigned NFLAG = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en_i,
  input  logic [irq_agg_pkg::ADDR_W-1:0]     addr_i,
  input  logic [NFLAG-1:0]                   wdata_i,
  output logic [NFLAG-1:0]                   en_o,
  output logic [NFLAG-1:0]                   sel_o,
  output logic [irq_agg_pkg::NLINE-1:0]      gate_o
);
  import irq_agg_pkg::*;
  logic [NFLAG-1:0] en_q, en_d, sel_q, sel_d;
  logic [NLINE-1:0] gate_q, gate_d;
  logic we_en, we_sel, we_gate;

  assign we_en   = wr_en_i && (addr_i == REG_EN);
  assign we_sel  = wr_en_i && (addr_i == REG_SEL);
  assign we_gate = wr_en_i && (addr_i == REG_GATE);

  always_comb begin
    en_d   = we_en   ? wdata_i : en_q;
    sel_d  = we_sel  ? wdata_i : sel_q;
    gate_d = we_gate ? wdata_i[NLINE-1:0] : gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      sel_q  <= '0;
      gate_q <= '0;
    end else begin
      en_q   <= en_d;
      sel_q  <= sel_d;
      gate_q <= gate_d;
    end
  end

  assign en_o   = en_q;
  assign sel_o  = sel_q;
  assign gate_o = gate_q;

  // R6: configuration is stable without a write
  p_cfg_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i) |=> ($stable(en_q) && $stable(sel_q) && $stable(gate_q)));
endmodule

// File: rtl/irq_agg_route.sv
module irq_agg_route #(
  parameter int unsigned NFLAG = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NFLAG-1:0]              flag_i,
  input  logic [NFLAG-1:0]              en_i,
  input  logic [NFLAG-1:0]              sel_i,
  input  logic [irq_agg_pkg::NLINE-1:0] gate_i,
  output logic [irq_agg_pkg::NLINE-1:0] irq_o
);
  import irq_agg_pkg::*;
  logic [NLINE-1:0] irq_d, irq_q;
  logic [NFLAG-1:0] live;

  assign live = flag_i & en_i;

  for (genvar k = 0; k < NLINE; k++) begin : g_line
    logic [NFLAG-1:0] hit;
    if (k == 0) begin : g_l0
      assign hit = live & ~sel_i;
    end else begin : g_l1
      assign hit = live & sel_i;
    end
    assign irq_d[k] = gate_i[k] & (|hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R9: a closed gate silences its line
  p_gate0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_i[0]) |=> !irq_q[0]);
  p_gate1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_i[1]) |=> !irq_q[1]);
  // R7: no enabled flags means both lines quiet
  p_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |=> (irq_q == '0));
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top #(
  parameter int unsigned NFLAG = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [NFLAG-1:0] wdata_i,
  output logic [NFLAG-1:0] rdata_o,
  output logic [1:0]       irq_o
);
  import irq_agg_pkg::*;
  logic [NFLAG-1:0] flag, en, sel;
  logic [NLINE-1:0] gate;
  logic clr_en;

  assign clr_en = wr_en_i && (addr_i == REG_FLAG);

  irq_agg_flags #(.NFLAG(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .clr_en_i(clr_en), .clr_mask_i(wdata_i), .flag_o(flag));

  irq_agg_regs #(.NFLAG(NFLAG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .en_o(en), .sel_o(sel), .gate_o(gate));

  irq_agg_route #(.NFLAG(NFLAG)) u_route (
    .clk(clk), .rst_n(rst_n), .flag_i(flag), .en_i(en), .sel_i(sel),
    .gate_i(gate), .irq_o(irq_o));

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_FLAG: rdata_o = flag;
      REG_EN:   rdata_o = en;
      REG_SEL:  rdata_o = sel;
      default:  rdata_o[NLINE-1:0] = gate;
    endcase
  end

  // R1: outputs quiet while reset held
  always_comb begin
    if (!rst_n) a_reset_r1: assert (irq_o == '0);
  end
endmodule

// File: tb/irq_agg_top_tb_top.sv
module irq_agg_top_tb_top;
  localparam int N = 32;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [N-1:0] evt = '0, wdata = '0, rdata;
  logic [1:0] addr = '0, irq;
  int errs = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_agg_top #(.NFLAG(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  // vector: en, sel, gate, event pulse, expected irq
  typedef struct packed {
    logic [31:0] en; logic [31:0] sel; logic [1:0] gate;
    logic [31:0] ev; logic [1:0] irq;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{32'h1,        32'h0,        2'b11, 32'h1,        2'b01},
    '{32'h1,        32'h1,        2'b11, 32'h1,        2'b10},
    '{32'h0,        32'h0,        2'b11, 32'hFFFF_FFFF, 2'b00},
    '{32'h8000_0001,32'h8000_0000,2'b11, 32'h8000_0001,2'b11},
    '{32'h8000_0001,32'h8000_0000,2'b01, 32'h8000_0001,2'b01},
    '{32'h8000_0001,32'h8000_0000,2'b10, 32'h8000_0001,2'b10},
    '{32'hF0,       32'hF0,       2'b11, 32'h0F,       2'b00},
    '{32'hFF,       32'h0F,       2'b11, 32'hF0,       2'b01}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(logic [31:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    chk("R1 irq", {30'b0, irq}, 0);
    rd(0, r); chk("R1 flags", r, 0);
    rd(1, r); chk("R1 en", r, 0);
    rst_n = 1;

    // R6 readback
    wr(1, 32'hA5A5_0F0F); rd(1, r); chk("R6 en", r, 32'hA5A5_0F0F);
    wr(2, 32'h1234_5678); rd(2, r); chk("R6 sel", r, 32'h1234_5678);
    wr(3, 32'hFFFF_FFFE); rd(3, r); chk("R6 gate", r, 32'h2);

    foreach (VECS[i]) begin
      wr(0, 32'hFFFF_FFFF);
      wr(1, VECS[i].en); wr(2, VECS[i].sel); wr(3, {30'b0, VECS[i].gate});
      pulse(VECS[i].ev);
      @(negedge clk);
      chk($sformatf("R8 R7 R9 vec%0d", i), {30'b0, irq}, {30'b0, VECS[i].irq});
      rd(0, r); chk($sformatf("R2 vec%0d flags", i), r, VECS[i].ev);
    end

    // R3/R4 partial clear; R10 read no side effect
    wr(1, 0); wr(0, 32'hFFFF_FFFF);
    pulse(32'h0000_00FF);
    rd(0, r); rd(0, r); chk("R10 R3 flags", r, 32'hFF);
    wr(0, 32'h0000_000F); rd(0, r); chk("R4 partial clear", r, 32'hF0);
    wr(0, 32'h0); rd(0, r); chk("R4 zero write", r, 32'hF0);

    // R2 held level sets once
    wr(0, 32'hFFFF_FFFF);
    @(negedge clk); evt = 32'h100;
    repeat (2) @(negedge clk);
    wr(0, 32'h100);
    repeat (2) @(negedge clk);
    rd(0, r); chk("R2 held level", r, 0);
    evt = 0;

    // R5 same-cycle clear and edge
    @(negedge clk); evt = 32'h200; @(negedge clk); evt = 0;
    @(negedge clk); wr_en = 1; addr = 0; wdata = 32'h200; evt = 32'h200;
    @(negedge clk); wr_en = 0; wdata = 0; evt = 0;
    rd(0, r); chk("R5 edge wins", r, 32'h200);

    // R8 live clear drops line
    wr(1, 32'h200); wr(2, 0); wr(3, 3);
    @(negedge clk); chk("R8 line0 up", {30'b0, irq}, 1);
    wr(0, 32'h200); @(negedge clk); chk("R8 line0 down", {30'b0, irq}, 0);

    // R1 reset clears flags
    pulse(32'h1); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(0, r); chk("R1 reset flags", r, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule